// File: doc/BRIEF.md
# Streaming Five-Sample Median Filter

This block is a running median over a stream of 32-bit unsigned samples. The producer presents a sample together with a valid strobe. For every sample it accepts, the block returns one result one clock later: the median of that sample and the four samples accepted just before it. The result comes with its own valid strobe. The producer may send a sample on every clock, or may leave gaps of any length. While the strobe is low, nothing inside the block moves.

The block does not sort the window. Each new sample is compared only against the four stored samples. The other six pairwise orderings in the window were already worked out when the older samples arrived, and they sit in small bit registers that shift along with the sample history. Ties are broken by age, and this gives all five window elements a strict order. The element with exactly two peers ranked above it is the median. A priority chain picks it, running from newest to oldest, and the oldest element is the fallback.

Top module: `median5_stream`

## Requirements
- R1: During and after a synchronous reset, and before any sample is accepted, `out_vld` is 0 and `med_out` is 0.
- R2: When `in_vld` is 1 on a rising edge, `in_data` is accepted. The result that follows is the median (third smallest) of that sample and the four samples accepted before it, where the four earlier ones are counted in acceptance order.
- R3: `out_vld` is 1 in exactly the cycle after each accepted sample, and the new median is present on `med_out` in that same cycle.
- R4: In a cycle with `in_vld` at 0, no state advances. `out_vld` is 0 in the following cycle, `med_out` keeps its value, and idle gaps change none of the later results.
- R5: The median is correct when some or all of the five window values are equal.
- R6: With a sample on every clock, one result comes out on every clock, with no stall.
- R7: Reset fills the four history slots with zero. Until five samples have been accepted, the medians count those zeros as window members.
- R8: Comparisons are unsigned over the full 32 bits. A value with bit 31 set ranks above any value with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 32 | Input sample |
| out_vld | output | 1 | Result strobe, one cycle after an accepted sample |
| med_out | output | 32 | Registered median of the five newest samples |

## Verification
Two functions can fall in the same cycle. The monitor compares a result produced by the previous sample while the driver presents the next sample, and this sample shifts the history and the stored comparison bits on the same edge. Back-to-back streams create this overlap on every clock. Streams with idle gaps separate the two functions, and in those gaps the bench checks that `out_vld` stays low and `med_out` holds. Every strobed result is judged against a model window of the last five accepted samples, which the bench sorts itself. The streams include heavy runs of repeated values and values with bit 31 set.

// File: rtl/med5_pkg.sv
package med5_pkg;
   // Window length the comparison-reuse scheme is built for.
   localparam int unsigned MED_WIN  = 5;
   // Number of peers ranked above the median element.
   localparam int unsigned MED_RANK = (MED_WIN - 1) / 2;
endpackage

// File: rtl/med5_hist.sv
// Sample history: DEPTH stored samples, tap 0 is the most recent accepted one.
module med5_hist #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           adv,
   input  logic [DATA_W-1:0]              new_smp,
   output logic [DEPTH-1:0][DATA_W-1:0]   taps
);
   for (genvar t = 0; t < DEPTH; t++) begin : g_tap
      always_ff @(posedge clk) begin
         if (rst) begin
            taps[t] <= '0;
         end else if (adv) begin
            if (t == 0) taps[t] <= new_smp;
            else        taps[t] <= taps[(t == 0) ? 0 : t-1];
         end
      end
   end
endmodule

// File: rtl/med5_rel.sv
// Pairwise ordering matrix. lt[i][j] (i<j) means element i < element j,
// element 0 being the newest sample. Only row 0 is computed fresh; rows
// 1..DEPTH-1 are earlier row-0 bits shifted down as samples are accepted.
module med5_rel #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned WIN   = DEPTH + 1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           adv,
   input  logic [DATA_W-1:0]              new_smp,
   input  logic [DEPTH-1:0][DATA_W-1:0]   taps,
   output logic [WIN-1:0][WIN-1:0]        lt
);
   logic [DEPTH-1:0] fresh;

   for (genvar m = 0; m < DEPTH; m++) begin : g_fresh
      assign fresh[m] = (new_smp < taps[m]);
   end

   // Level L holds "element L < element L+1+m" for m = 0..DEPTH-1-L.
   for (genvar L = 1; L < DEPTH; L++) begin : g_lvl
      logic [DEPTH-1-L:0] q;
      if (L == 1) begin : g_first
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (adv) q <= fresh[DEPTH-2:0];
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (adv) q <= g_lvl[L-1].q[DEPTH-1-L:0];
         end
      end
   end

   for (genvar i = 0; i < WIN; i++) begin : g_row
      for (genvar j = 0; j < WIN; j++) begin : g_col
         if (j <= i) begin : g_none
            assign lt[i][j] = 1'b0;
         end else if (i == 0) begin : g_new
            assign lt[i][j] = fresh[j-1];
         end else begin : g_old
            assign lt[i][j] = g_lvl[i].q[j-i-1];
         end
      end
   end
endmodule

// File: rtl/med5_pick.sv
// Rank each element from the ordering matrix (ties resolved by age through
// the strict '<' bits) and pick the one with exactly RANK peers above it.
module med5_pick #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WIN    = 5,
   parameter int unsigned RANK   = 2
) (
   input  logic [WIN-1:0][DATA_W-1:0]  elems,
   input  logic [WIN-1:0][WIN-1:0]     lt,
   output logic [DATA_W-1:0]           med
);
   logic [WIN-1:0] hit;

   always_comb begin
      for (int k = 0; k < WIN; k++) begin
         int cnt;
         cnt = 0;
         for (int j = 0; j < WIN; j++) begin
            if (j > k)      cnt = cnt + int'(lt[k][j]);
            else if (j < k) cnt = cnt + int'(!lt[j][k]);
         end
         hit[k] = (cnt == int'(RANK));
      end
   end

   always_comb begin
      med = elems[WIN-1];
      for (int k = WIN - 2; k >= 0; k--) begin
         if (hit[k]) med = elems[k];
      end
   end
endmodule

// File: rtl/median5_stream.sv
module median5_stream #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WIN    = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_vld,
   output logic [DATA_W-1:0] med_out
);
   import med5_pkg::*;

   localparam int unsigned DEPTH = WIN - 1;
   localparam int unsigned RANK  = (WIN - 1) / 2;

   if (WIN != MED_WIN) begin : g_bad_win
      $error("median5_stream: WIN must be %0d", MED_WIN);
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("median5_stream: DATA_W must be at least 1");
   end

   logic [DEPTH-1:0][DATA_W-1:0] hist_taps;
   logic [WIN-1:0][WIN-1:0]      rel;
   logic [WIN-1:0][DATA_W-1:0]   window;
   logic [DATA_W-1:0]            pick;

   med5_hist #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hist (
      .clk(clk), .rst(rst), .adv(in_vld), .new_smp(in_data), .taps(hist_taps)
   );

   med5_rel #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rel (
      .clk(clk), .rst(rst), .adv(in_vld), .new_smp(in_data),
      .taps(hist_taps), .lt(rel)
   );

   for (genvar k = 0; k < WIN; k++) begin : g_win
      if (k == 0) begin : g_new
         assign window[k] = in_data;
      end else begin : g_old
         assign window[k] = hist_taps[k-1];
      end
   end

   med5_pick #(.DATA_W(DATA_W), .WIN(WIN), .RANK(RANK)) u_pick (
      .elems(window), .lt(rel), .med(pick)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
         med_out <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) med_out <= pick;
      end
   end
endmodule

// File: rtl/median5_stream_chk.sv
module median5_stream_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WIN    = 5
) (
   input logic                            clk,
   input logic                            rst,
   input logic                            in_vld,
   input logic [DATA_W-1:0]               in_data,
   input logic                            out_vld,
   input logic [DATA_W-1:0]               med_out,
   input logic [WIN-2:0][DATA_W-1:0]      taps
);
   p_strobe_follows_r3: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   p_hold_result_r4: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(med_out));

   p_hold_history_r4: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(taps));

   p_newest_stored_r2: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> (taps[0] == $past(in_data)));
endmodule

bind median5_stream median5_stream_chk #(.DATA_W(DATA_W), .WIN(WIN)) u_chk (
   .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
   .out_vld(out_vld), .med_out(med_out), .taps(hist_taps)
);

// File: tb/median5_stream_test.sv
module median5_stream_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_vld;
   logic [31:0] med_out;

   median5_stream uut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
      .out_vld(out_vld), .med_out(med_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;
   logic [31:0] model [5];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic [31:0] last_q = '0;
   logic [31:0] rs = 32'h1234_5677;

   function automatic logic [31:0] ref_median(input logic [31:0] w [5]);
      logic [31:0] a [5];
      logic [31:0] t;
      for (int i = 0; i < 5; i++) a[i] = w[i];
      for (int i = 0; i < 4; i++)
         for (int j = 0; j < 4 - i; j++)
            if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
      return a[2];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs;
   endfunction

   // Driver: present one sample and push its expected median.
   task automatic send(input logic [31:0] d, input string req);
      @(negedge clk);
      in_vld  = 1'b1;
      in_data = d;
      for (int i = 4; i > 0; i--) model[i] = model[i-1];
      model[0] = d;
      exp_q.push_back(ref_median(model));
      tag_q.push_back(req);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld  = 1'b0;
         in_data = rnd();
      end
   endtask

   // Monitor: compare every strobed result, check hold when no strobe (R4).
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_vld) begin
            if (exp_q.size() == 0) begin
               n_run++; n_fail++;
               $display("FAIL R3: actual strobe 1 expected 0 (no pending sample)");
            end else begin
               string req;
               logic [31:0] e;
               e = exp_q.pop_front();
               req = tag_q.pop_front();
               check(req, med_out, e);
            end
            last_q = med_out;
         end else begin
            check("R4", med_out, last_q);
         end
      end
   end

   initial begin
      for (int i = 0; i < 5; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", {31'd0, out_vld}, 32'd0);
      check("R1", med_out, 32'd0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", {31'd0, out_vld}, 32'd0);
      // R7: zero-filled history while the window fills
      send(32'd100, "R7"); send(32'd200, "R7"); send(32'd300, "R7");
      send(32'd400, "R7"); send(32'd50, "R7");
      idle(2);
      // R8: unsigned ordering with bit 31 set
      send(32'hFFFF_FFF0, "R8"); send(32'h8000_0000, "R8"); send(32'd5, "R8");
      send(32'h7FFF_FFFF, "R8"); send(32'hF000_0000, "R8"); send(32'h8000_0001, "R8");
      // R6: back-to-back stream
      for (int i = 0; i < 40; i++) send(rnd(), "R6");
      // R4: samples separated by idle gaps
      for (int i = 0; i < 20; i++) begin
         send(rnd(), "R4");
         idle(1 + (i % 3));
      end
      // R5: equal values
      for (int i = 0; i < 5; i++) send(32'd7, "R5");
      send(32'd3, "R5"); send(32'd3, "R5"); send(32'd9, "R5");
      send(32'd9, "R5"); send(32'd3, "R5");
      for (int i = 0; i < 60; i++) begin
         logic [31:0] v;
         v = rnd();
         send({30'd0, v[1:0]}, "R5");
      end
      // R2: mixed stream with occasional gaps
      for (int i = 0; i < 80; i++) begin
         logic [31:0] v;
         v = rnd();
         send(rnd(), "R2");
         if (v[2:0] == 3'd0) idle(1);
      end
      idle(4);
      check("R3", exp_q.size(), 32'd0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule